// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a watchdog timer behind a small 32-bit register window. Software selects a period with a 4-bit range code, turns the watchdog on, and must then feed it by writing a fixed key word before the down-counter reaches zero. Once turned on, the watchdog stays on until the hardware reset. Nothing written over the bus can turn it off.

Two responses to a missed feed are available. In direct mode, an expiry at once starts a system reset pulse of fixed length. In interrupt-first mode, the first expiry raises an interrupt and reloads the counter. If that interrupt is still pending at the following expiry, the reset pulse follows. Reading the acknowledge register clears the interrupt and also reloads the counter.

The bus side is plain: a write strobe, a read strobe, a byte address and 32-bit data. There is no streaming data path, so no valid/ready handshake is used and no back-pressure exists. Read data is combinational while the read strobe is high and is zero otherwise.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, `irq` and `sys_rst` are 0, the control and range registers read 0, and from the first clock after reset the count register reads the reload value for code 0.
- R2: Control bit 0 (offset 0x00) turns the watchdog on and cannot be cleared by a write. Control bit 1 picks interrupt-first mode. Bit 1 can be written only while bit 0 is still 0, and a write that sets bit 0 also sets bit 1 from the same data.
- R3: The reload value is 2^(BASE_SHIFT+code), where code is the range register at offset 0x04. While the watchdog is off, the count register (offset 0x08) reads the reload value for the current code. While on, the count drops by one each cycle.
- R4: A write of exactly 0x00000076 to offset 0x0C reloads the counter. A write of any other value to that offset leaves the count running.
- R5: A new range code written while the watchdog is running changes nothing until the next reload.
- R6: In interrupt-first mode, the first expiry sets `irq` and status bit 0 (offset 0x10), and the counter reloads. An expiry happens on the clock after the count reads zero.
- R7: In interrupt-first mode, an expiry while `irq` is pending clears `irq` and drives `sys_rst` high for exactly PULSE_LEN cycles.
- R8: In direct mode, an expiry drives `sys_rst` for PULSE_LEN cycles and never sets `irq`.
- R9: A read of offset 0x14 clears `irq` and reloads the counter, so the next expiry raises an interrupt again rather than a reset.
- R10: While `sys_rst` is high, the counter holds its reload value and a key write has no effect. When the pulse ends, the counter reloads and runs again.
- R11: Offsets outside the six registers read 0, and writes to them change nothing. Offsets 0x0C and 0x14 read 0.
- R12: While the watchdog is off, neither `irq` nor `sys_rst` is ever asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Pending timeout interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
The assertions take for granted that at most one of the two strobes is high in a cycle and that PULSE_LEN is at least 2. The bench always drives exactly one strobe for a single cycle. It uses a pulse length of 8 and a small BASE_SHIFT, so that several full expiry sequences fit in a short run. The non-key restart values are drawn at random, and any draw that equals the key is replaced, so a value that is not the key never reloads the counter by chance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_RANGE = 'h04;
  localparam int OFS_COUNT = 'h08;
  localparam int OFS_KICK  = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_ACK   = 'h14;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic irq_first;
    logic on;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output logic [31:0]       rdata_o,
  output wdt_ctrl_t         ctrl_o,
  output logic [CODE_W-1:0] code_o,
  output logic              kick_o,
  output logic              ack_o
);
  wdt_ctrl_t         ctrl_q;
  logic [CODE_W-1:0] code_q;
  logic              hit_ctrl, hit_range, hit_count, hit_kick, hit_stat, hit_ack;

  assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
  assign hit_range = (addr == ADDR_W'(OFS_RANGE));
  assign hit_count = (addr == ADDR_W'(OFS_COUNT));
  assign hit_kick  = (addr == ADDR_W'(OFS_KICK));
  assign hit_stat  = (addr == ADDR_W'(OFS_STAT));
  assign hit_ack   = (addr == ADDR_W'(OFS_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      code_q <= '0;
    end else if (wr_en) begin
      if (hit_ctrl) begin
        ctrl_q.on <= ctrl_q.on | wdata[0];
        if (!ctrl_q.on) ctrl_q.irq_first <= wdata[1];
      end
      if (hit_range) code_q <= wdata[CODE_W-1:0];
    end
  end

  assign kick_o = wr_en && hit_kick && (wdata == KICK_KEY);
  assign ack_o  = rd_en && hit_ack;
  assign ctrl_o = ctrl_q;
  assign code_o = code_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (hit_ctrl)  rdata_o = {30'd0, ctrl_q.irq_first, ctrl_q.on};
      if (hit_range) rdata_o = 32'(code_q);
      if (hit_count) rdata_o = 32'(cnt_i);
      if (hit_stat)  rdata_o = {31'd0, irq_i};
    end
  end

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.on |=> ctrl_q.on);
  assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.on |=> $stable(ctrl_q.irq_first));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             hold_i,
  input  logic             release_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // A software reload in the same cycle wins over an expiry.
  assign expire_o = en_i && !hold_i && !load_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!en_i)                cnt_q <= load_val_i;
    else if (hold_i)               cnt_q <= release_i ? load_val_i : cnt_q;
    else if (load_i || expire_o)   cnt_q <= load_val_i;
    else                           cnt_q <= cnt_q - 1'b1;
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !hold_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !hold_i && load_i) |=> (cnt_q == $past(load_val_i)));
  assert_hold_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && hold_i && !release_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_seq.sv
module wdt_seq #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic irq_first_i,
  input  logic expire_i,
  input  logic ack_i,
  output logic irq_o,
  output logic hold_o,
  output logic release_o,
  output logic sys_rst_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          irq_q;
  logic [PW-1:0] pulse_q;

  assign hold_o    = (pulse_q != '0);
  assign release_o = (pulse_q == PW'(1));
  assign sys_rst_o = hold_o;
  assign irq_o     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else if (expire_i) begin
      if (irq_first_i && !irq_q) begin
        irq_q <= 1'b1;
      end else begin
        irq_q   <= 1'b0;
        pulse_q <= PW'(PULSE_LEN);
      end
    end else begin
      if (ack_i)          irq_q   <= 1'b0;
      if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end
  end

  assert_irq_before_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_rst_o) && irq_first_i) |-> $past(irq_q));
  assert_pulse_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |=> sys_rst_o);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, sys_rst_o}));
  assert_direct_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_first_i |-> !irq_q);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !irq_q);
  assert_quiet_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!irq_q && !sys_rst_o));
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CODE_W     = 4,
  parameter int BASE_SHIFT = 16,
  parameter int PULSE_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              sys_rst
);
  localparam int CNT_W = BASE_SHIFT + (1 << CODE_W);

  wdt_ctrl_t         ctrl;
  logic [CODE_W-1:0] code;
  logic              kick, ack, expire, hold, release_c;
  logic [CNT_W-1:0]  cnt, load_val;

  assign load_val = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_SHIFT + int'(code));

  wdt_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_i(cnt), .irq_i(irq), .rdata_o(rdata),
    .ctrl_o(ctrl), .code_o(code), .kick_o(kick), .ack_o(ack)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl.on), .load_i(kick | ack),
    .hold_i(hold), .release_i(release_c), .load_val_i(load_val),
    .cnt_o(cnt), .expire_o(expire)
  );

  wdt_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl.on), .irq_first_i(ctrl.irq_first),
    .expire_i(expire), .ack_i(ack), .irq_o(irq), .hold_o(hold),
    .release_o(release_c), .sys_rst_o(sys_rst)
  );
endmodule

// File: tb/twostage_wdt_test.sv
`timescale 1ns/1ps
module twostage_wdt_test;
  localparam int BASE = 3;
  localparam int PL   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;

  twostage_wdt #(.ADDR_W(8), .CODE_W(4), .BASE_SHIFT(BASE), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int reload(input int code);
    return 1 << (BASE + code);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tw, e1, e2, c, tl, R;
    void'($urandom(32'd20240611));

    // R1 reset state
    do_reset();
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sys_rst", {31'd0, sys_rst}, 0);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 range", v, 0);
    rd(8'h08, v); chk("R1 count", v, reload(0));

    // R11 unmapped and write-only offsets
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h03, 32'h0000_0003);
    rd(8'h18, v); chk("R11 unmapped read", v, 0);
    rd(8'h0C, v); chk("R11 kick read", v, 0);
    rd(8'h14, v); chk("R11 ack read", v, 0);
    rd(8'h00, v); chk("R11 ctrl untouched", v, 0);
    rd(8'h04, v); chk("R11 range untouched", v, 0);

    // R3 random range codes while off
    for (int i = 0; i < 20; i++) begin
      int code;
      code = int'($urandom % 16);
      wr(8'h04, 32'(code));
      rd(8'h04, v); chk("R3 range readback", v, 32'(code));
      rd(8'h08, v); chk("R3 idle reload", v, 32'(reload(code)));
    end
    // R12 off: long wait on shortest period
    wr(8'h04, 0);
    repeat (40) @(posedge clk); #1;
    chk("R12 irq off", {31'd0, irq}, 0);
    chk("R12 sys_rst off", {31'd0, sys_rst}, 0);

    // Direct mode: R2, R3, R8, R7, R10
    do_reset();
    R = reload(2);
    wr(8'h04, 2);
    wr(8'h00, 1); tw = cyc;
    c = cyc; rd(8'h08, v); chk("R3 count step", v, 32'(R - (c - tw)));
    wr(8'h00, 0); rd(8'h00, v); chk("R2 enable sticky", v, 1);
    wr(8'h00, 3); rd(8'h00, v); chk("R2 mode locked", v, 1);
    wait_to(tw + R);     chk("R8 before expiry", {31'd0, sys_rst}, 0);
    wait_to(tw + R + 1); chk("R8 reset pulse", {31'd0, sys_rst}, 1);
    chk("R8 no irq", {31'd0, irq}, 0);
    e2 = tw + R + 1;
    wait_to(e2 + 1);
    wr(8'h0C, 32'h76);
    rd(8'h08, v); chk("R10 held during pulse", v, 32'(R));
    wait_to(e2 + PL - 1); chk("R7 pulse still high", {31'd0, sys_rst}, 1);
    wait_to(e2 + PL);     chk("R7 pulse ends", {31'd0, sys_rst}, 0);
    wait_to(e2 + PL + R);     chk("R10 runs after pulse", {31'd0, sys_rst}, 0);
    wait_to(e2 + PL + R + 1); chk("R10 next expiry", {31'd0, sys_rst}, 1);

    // Interrupt-first mode: R6, R7
    do_reset();
    R = reload(1);
    wr(8'h04, 1);
    wr(8'h00, 3); tw = cyc;
    wait_to(tw + R);     chk("R6 no irq yet", {31'd0, irq}, 0);
    wait_to(tw + R + 1); chk("R6 first expiry irq", {31'd0, irq}, 1);
    chk("R6 no reset", {31'd0, sys_rst}, 0);
    e1 = tw + R + 1;
    rd(8'h10, v); chk("R6 status bit", v, 1);
    c = cyc; rd(8'h08, v); chk("R6 reloaded", v, 32'(R - (c - e1)));
    wait_to(e1 + R);     chk("R7 irq pending", {31'd0, irq}, 1);
    chk("R7 no reset yet", {31'd0, sys_rst}, 0);
    wait_to(e1 + R + 1); chk("R7 second expiry reset", {31'd0, sys_rst}, 1);
    chk("R7 irq cleared", {31'd0, irq}, 0);

    // Acknowledge: R9
    do_reset();
    R = reload(1);
    wr(8'h04, 1);
    wr(8'h00, 3); tw = cyc;
    wait_to(tw + R + 1); chk("R9 irq raised", {31'd0, irq}, 1);
    c = cyc; rd(8'h14, v); chk("R11 ack reads zero", v, 0);
    chk("R9 irq cleared", {31'd0, irq}, 0);
    rd(8'h10, v); chk("R9 status cleared", v, 0);
    wait_to(c + R + 1); chk("R9 quiet before", {31'd0, irq | sys_rst}, 0);
    wait_to(c + R + 2); chk("R9 irq again", {31'd0, irq}, 1);
    chk("R9 no reset", {31'd0, sys_rst}, 0);

    // Restart key, random values: R4
    do_reset();
    R = reload(4);
    wr(8'h04, 4);
    wr(8'h00, 1); tl = cyc;
    for (int i = 0; i < 10; i++) begin
      int gap;
      gap = int'($urandom % 4);
      repeat (gap) begin @(posedge clk); #1; end
      if ($urandom % 2 == 0) begin
        wr(8'h0C, 32'h76); tl = cyc;
      end else begin
        logic [31:0] bad;
        bad = $urandom;
        if (bad == 32'h76) bad = 32'h77;
        wr(8'h0C, bad);
      end
      c = cyc; rd(8'h08, v); chk("R4 kick handling", v, 32'(R - (c - tl)));
    end
    chk("R4 no reset", {31'd0, sys_rst}, 0);

    // Range change takes effect on reload: R5
    do_reset();
    wr(8'h04, 2);
    wr(8'h00, 1); tw = cyc;
    wr(8'h04, 4);
    c = cyc; rd(8'h08, v); chk("R5 old period kept", v, 32'(reload(2) - (c - tw)));
    wr(8'h0C, 32'h76); tl = cyc;
    c = cyc; rd(8'h08, v); chk("R5 new period used", v, 32'(reload(4) - (c - tl)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule